// File: doc/BRIEF.md
# Indirect Control/Status Register File

This block is the host-facing register interface of a network controller. The host reaches every register through two 16-bit locations on a simple write-strobe bus. A write to the selector location picks a register number. Accesses to the data location then read or write the register that was picked. The selector location reads back the number it holds.

Register 0 is the command/status word. It takes commands to initialise, start and stop the controller, to demand a transmit poll and to enable the interrupt. It also shows the running state and seven sticky event flags, which the receive and transmit engines set through dedicated event inputs. The other registers hold the configuration the engines need: the initialisation-block address, three bus-configuration bits, a 64-bit multicast filter and a mode word. These are only accepted while the controller is stopped. The block drives one level interrupt output.

Reads are combinational from registered state, so the data location shows the selected register in the same cycle that the selection is presented. A write takes effect at the next rising clock edge.

Top module: `nic_csr_file`

## Requirements
- R1: A write to the selector location (bus_port=1) loads the low 4 bits of the written word as the register number, and reading the selector location returns that number with the upper 12 bits zero. A data-location access (bus_port=0) targets the selected register. Register numbers 4–7 and 12–14 read as 0 and ignore writes.
- R2: After reset, register 0 reads 0x0004 (only the stop bit set), every other register reads 0, irq and tx_demand are low, and the selector holds 0.
- R3: A register-0 write with bit 2 set leaves the block stopped no matter what else is written. Bit 2 reads 1, and init (bit 0), start (bit 1), interrupt enable (bit 6), transmitter-on (bit 4) and receiver-on (bit 5) all read 0. For example, writing 0x0005 reads back as 0x0004.
- R4: A register-0 write with bit 2 clear behaves as follows. Bit 1 = 1 sets start, transmitter-on and receiver-on, and clears stop. Bit 0 = 1 sets init and clears stop. Writing 0 to bits 0 and 1 leaves them unchanged. Bit 6 takes the written value. Stop and transmitter-on are never both set.
- R5: A register-0 write with bit 3 set and bit 2 clear produces tx_demand high for exactly the one cycle after the write edge. Bit 3 always reads 0.
- R6: The event inputs init-done, tx-interrupt, rx-interrupt, memory-error, missed-frame, collision-error and babble set register-0 bits 8, 9, 10, 11, 12, 13 and 14 respectively, and those bits stay set. Writing 1 to such a bit clears it, and writing 0 leaves it unchanged. An event arriving in the same cycle as its clear leaves the bit set.
- R7: Register-0 bit 15 reads as the OR of bits 11–14. Bit 7 reads as the OR of bits 8–14.
- R8: irq is high exactly when register-0 bits 7 and 6 are both set.
- R9: Register 1 holds init_addr[15:0]. Register 2 holds init_addr[23:16] in its low 8 bits, and its upper bits read 0.
- R10: Register 3 bit 0 is byte control, bit 1 is address-latch control and bit 2 is byte swap. Together they drive bus_cfg[2:0], and bits 15:3 read 0.
- R11: Registers 8, 9, 10 and 11 hold mcast_filter bits 15:0, 31:16, 47:32 and 63:48. Register 15 is the mode word (mode_word), and its bit 15 drives promisc.
- R12: Writes to registers 1, 2, 3, 8–11 and 15 take effect only while the stop bit is set. At any other time they are ignored and the register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the addressed location |
| bus_port | input | 1 | 0 = data location, 1 = selector location |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the addressed location |
| ev_init_done | input | 1 | Initialisation finished event |
| ev_tx_int | input | 1 | Transmit completion event |
| ev_rx_int | input | 1 | Receive completion event |
| ev_mem_err | input | 1 | Memory access error event |
| ev_missed | input | 1 | Missed frame event |
| ev_coll_err | input | 1 | Collision error event |
| ev_babble | input | 1 | Transmitter babble event |
| irq | output | 1 | Interrupt request |
| tx_demand | output | 1 | One-cycle transmit poll request |
| tx_on | output | 1 | Transmitter enabled |
| rx_on | output | 1 | Receiver enabled |
| init_req | output | 1 | Initialise command pending |
| stopped | output | 1 | Controller stopped |
| init_addr | output | 24 | Initialisation-block address |
| bus_cfg | output | 3 | Byte swap, address-latch and byte control bits |
| mcast_filter | output | 64 | Multicast filter |
| promisc | output | 1 | Promiscuous mode |
| mode_word | output | 16 | Mode register contents |

## Verification
The bench first sweeps every register number through the selector and checks what the data location returns. A design that decoded the number wrongly, or that backed the unused numbers with storage, would return a stale pattern there.

It then writes combined command words to register 0. Writing init together with stop must read back as stop alone, and a design that let init or start survive the stop bit would show extra bits. Each of the seven event flags is raised in turn, written with 0 and then cleared with 1, while the two summary bits and irq are watched. A design that stored the summaries, or that treated a 0 write as a clear, diverges in the read word. The bench also raises an event in the same cycle as its clear, where a clear-first design would lose the event.

Finally, the configuration registers are written once while stopped and once while running. A design with no stop lock would overwrite its address and filter while running.

// File: rtl/nic_csr_pkg.sv
package nic_csr_pkg;
  localparam int SEL_W     = 4;
  localparam int WORD_W    = 16;
  localparam int N_EVENTS  = 7;

  localparam logic [SEL_W-1:0] REG_CMD     = 4'd0;
  localparam logic [SEL_W-1:0] REG_IADR_LO = 4'd1;
  localparam logic [SEL_W-1:0] REG_IADR_HI = 4'd2;
  localparam logic [SEL_W-1:0] REG_BUSCFG  = 4'd3;
  localparam int               REG_FILT0   = 8;
  localparam logic [SEL_W-1:0] REG_MODE    = 4'd15;

  localparam int B_INIT  = 0;
  localparam int B_START = 1;
  localparam int B_STOP  = 2;
  localparam int B_TDMD  = 3;
  localparam int B_IE    = 6;
  localparam int B_FLAG0 = 8;

  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/nic_csr_cmd.sv
module nic_csr_cmd
  import nic_csr_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_cmd,
  input  word_t               wdata,
  input  logic [N_EVENTS-1:0] ev,
  output word_t               stat_word,
  output logic [N_EVENTS-1:0] flags,
  output logic                init_q,
  output logic                stop_q,
  output logic                run_q,
  output logic                tdmd_q,
  output logic                irq
);
  logic                init_d, start_d, start_q, stop_d, ie_d, ie_q, run_d, tdmd_d;
  logic [N_EVENTS-1:0] flag_d, flag_q;
  logic                err_sum, int_sum;
  logic                unused_wbits;

  assign unused_wbits = ^{wdata[15], wdata[7], wdata[5:4]};

  always_comb begin
    init_d  = init_q;
    start_d = start_q;
    stop_d  = stop_q;
    ie_d    = ie_q;
    run_d   = run_q;
    tdmd_d  = 1'b0;
    flag_d  = flag_q | ev;
    if (wr_cmd) begin
      flag_d = (flag_q & ~wdata[B_FLAG0 +: N_EVENTS]) | ev;
      if (wdata[B_STOP]) begin
        stop_d  = 1'b1;
        init_d  = 1'b0;
        start_d = 1'b0;
        ie_d    = 1'b0;
        run_d   = 1'b0;
      end else begin
        ie_d   = wdata[B_IE];
        tdmd_d = wdata[B_TDMD];
        if (wdata[B_INIT]) begin
          init_d = 1'b1;
          stop_d = 1'b0;
        end
        if (wdata[B_START]) begin
          start_d = 1'b1;
          run_d   = 1'b1;
          stop_d  = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_q  <= 1'b0;
      start_q <= 1'b0;
      stop_q  <= 1'b1;
      ie_q    <= 1'b0;
      run_q   <= 1'b0;
      tdmd_q  <= 1'b0;
      flag_q  <= '0;
    end else begin
      init_q  <= init_d;
      start_q <= start_d;
      stop_q  <= stop_d;
      ie_q    <= ie_d;
      run_q   <= run_d;
      tdmd_q  <= tdmd_d;
      flag_q  <= flag_d;
    end
  end

  assign err_sum   = |flag_q[N_EVENTS-1:3];
  assign int_sum   = |flag_q;
  assign stat_word = {err_sum, flag_q, int_sum, ie_q, run_q, run_q, 1'b0, stop_q, start_q, init_q};
  assign flags     = flag_q;
  assign irq       = int_sum & ie_q;
endmodule

// File: rtl/nic_csr_cfg.sv
module nic_csr_cfg
  import nic_csr_pkg::*;
#(
  parameter int ADDR_HI_W = 8,
  parameter int N_FILT    = 4,
  parameter int CFG_W     = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [SEL_W-1:0]         sel,
  input  word_t                    wdata,
  output word_t                    rd_word,
  output logic [WORD_W+ADDR_HI_W-1:0] init_addr,
  output logic [CFG_W-1:0]         bus_cfg,
  output logic [WORD_W*N_FILT-1:0] filt,
  output word_t                    mode_q
);
  word_t                 lo_q;
  logic [ADDR_HI_W-1:0]  hi_q;
  logic [CFG_W-1:0]      cfg_q;
  word_t                 filt_q [N_FILT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q   <= '0;
      hi_q   <= '0;
      cfg_q  <= '0;
      mode_q <= '0;
    end else begin
      if (wr_en && sel == REG_IADR_LO) lo_q   <= wdata;
      if (wr_en && sel == REG_IADR_HI) hi_q   <= wdata[ADDR_HI_W-1:0];
      if (wr_en && sel == REG_BUSCFG)  cfg_q  <= wdata[CFG_W-1:0];
      if (wr_en && sel == REG_MODE)    mode_q <= wdata;
    end
  end

  for (genvar g = 0; g < N_FILT; g++) begin : g_filt
    localparam logic [SEL_W-1:0] MY_SEL = SEL_W'(REG_FILT0 + g);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     filt_q[g] <= '0;
      else if (wr_en && sel == MY_SEL) filt_q[g] <= wdata;
    end
    assign filt[g*WORD_W +: WORD_W] = filt_q[g];
  end

  always_comb begin
    rd_word = '0;
    if (sel == REG_IADR_LO) rd_word = lo_q;
    if (sel == REG_IADR_HI) rd_word = WORD_W'(hi_q);
    if (sel == REG_BUSCFG)  rd_word = WORD_W'(cfg_q);
    if (sel == REG_MODE)    rd_word = mode_q;
    for (int g = 0; g < N_FILT; g++)
      if (sel == SEL_W'(REG_FILT0 + g)) rd_word = filt_q[g];
  end

  assign init_addr = {hi_q, lo_q};
  assign bus_cfg   = cfg_q;
endmodule

// File: rtl/nic_csr_file.sv
module nic_csr_file
  import nic_csr_pkg::*;
#(
  parameter int ADDR_HI_W = 8,
  parameter int N_FILT    = 4,
  parameter int CFG_W     = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bus_wr,
  input  logic                        bus_port,
  input  logic [15:0]                 bus_wdata,
  output logic [15:0]                 bus_rdata,
  input  logic                        ev_init_done,
  input  logic                        ev_tx_int,
  input  logic                        ev_rx_int,
  input  logic                        ev_mem_err,
  input  logic                        ev_missed,
  input  logic                        ev_coll_err,
  input  logic                        ev_babble,
  output logic                        irq,
  output logic                        tx_demand,
  output logic                        tx_on,
  output logic                        rx_on,
  output logic                        init_req,
  output logic                        stopped,
  output logic [16+ADDR_HI_W-1:0]     init_addr,
  output logic [CFG_W-1:0]            bus_cfg,
  output logic [16*N_FILT-1:0]        mcast_filter,
  output logic                        promisc,
  output logic [15:0]                 mode_word
);
  logic [1:0]          rst_sync_q;
  logic                rst_int_n;
  logic [SEL_W-1:0]    sel_q;
  logic                sel_en;
  logic                wr_cmd, wr_cfg;
  logic [N_EVENTS-1:0] ev_vec, flag_w;
  word_t               stat_word, cfg_word;
  logic                run_w;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign sel_en = bus_wr & bus_port;
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  sel_q <= '0;
    else if (sel_en) sel_q <= bus_wdata[SEL_W-1:0];
  end

  assign ev_vec = {ev_babble, ev_coll_err, ev_missed, ev_mem_err, ev_rx_int, ev_tx_int, ev_init_done};
  assign wr_cmd = bus_wr & ~bus_port & (sel_q == REG_CMD);
  assign wr_cfg = bus_wr & ~bus_port & stopped & (sel_q != REG_CMD);

  nic_csr_cmd u_cmd (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .wr_cmd    (wr_cmd),
    .wdata     (bus_wdata),
    .ev        (ev_vec),
    .stat_word (stat_word),
    .flags     (flag_w),
    .init_q    (init_req),
    .stop_q    (stopped),
    .run_q     (run_w),
    .tdmd_q    (tx_demand),
    .irq       (irq)
  );

  nic_csr_cfg #(
    .ADDR_HI_W (ADDR_HI_W),
    .N_FILT    (N_FILT),
    .CFG_W     (CFG_W)
  ) u_cfg (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .wr_en     (wr_cfg),
    .sel       (sel_q),
    .wdata     (bus_wdata),
    .rd_word   (cfg_word),
    .init_addr (init_addr),
    .bus_cfg   (bus_cfg),
    .filt      (mcast_filter),
    .mode_q    (mode_word)
  );

  assign tx_on     = run_w;
  assign rx_on     = run_w;
  assign promisc   = mode_word[15];
  assign bus_rdata = bus_port ? {{(16-SEL_W){1'b0}}, sel_q}
                              : ((sel_q == REG_CMD) ? stat_word : cfg_word);
endmodule

// File: rtl/nic_csr_chk.sv
module nic_csr_chk #(
  parameter int IA_W = 24
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_wr,
  input logic            bus_port,
  input logic [15:0]     bus_wdata,
  input logic [3:0]      sel_q,
  input logic [6:0]      ev_vec,
  input logic [6:0]      flag_w,
  input logic            irq,
  input logic            tx_demand,
  input logic            tx_on,
  input logic            rx_on,
  input logic            init_req,
  input logic            stopped,
  input logic [IA_W-1:0] init_addr
);
  AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_port && sel_q == 4'd0 && bus_wdata[2]) |=> (stopped && !init_req && !tx_on && !rx_on)); // R3

  AST_STOP_NOT_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
    stopped |-> !tx_on); // R4

  AST_TDMD_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_demand |-> $past(bus_wr && !bus_port && sel_q == 4'd0 && bus_wdata[3] && !bus_wdata[2])); // R5

  AST_EVENT_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_vec != 7'd0) |=> ((flag_w & $past(ev_vec)) == $past(ev_vec))); // R6

  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flag_w != 7'd0)); // R8

  AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !stopped |=> $stable(init_addr)); // R12
endmodule

bind nic_csr_file nic_csr_chk #(.IA_W(16+ADDR_HI_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_int_n),
  .bus_wr    (bus_wr),
  .bus_port  (bus_port),
  .bus_wdata (bus_wdata),
  .sel_q     (sel_q),
  .ev_vec    (ev_vec),
  .flag_w    (flag_w),
  .irq       (irq),
  .tx_demand (tx_demand),
  .tx_on     (tx_on),
  .rx_on     (rx_on),
  .init_req  (init_req),
  .stopped   (stopped),
  .init_addr (init_addr)
);

// File: tb/nic_csr_file_tb.sv
module nic_csr_file_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_port = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [6:0]  ev = '0;
  logic        irq, tx_demand, tx_on, rx_on, init_req, stopped, promisc;
  logic [23:0] init_addr;
  logic [2:0]  bus_cfg;
  logic [63:0] mcast_filter;
  logic [15:0] mode_word;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  nic_csr_file u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_port(bus_port),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ev_init_done(ev[0]), .ev_tx_int(ev[1]), .ev_rx_int(ev[2]), .ev_mem_err(ev[3]),
    .ev_missed(ev[4]), .ev_coll_err(ev[5]), .ev_babble(ev[6]),
    .irq(irq), .tx_demand(tx_demand), .tx_on(tx_on), .rx_on(rx_on),
    .init_req(init_req), .stopped(stopped), .init_addr(init_addr),
    .bus_cfg(bus_cfg), .mcast_filter(mcast_filter), .promisc(promisc),
    .mode_word(mode_word)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic port, input logic [15:0] v);
    @(negedge clk);
    bus_port = port; bus_wdata = v; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic port, output logic [15:0] v);
    bus_port = port;
    #2;
    v = bus_rdata;
  endtask

  task automatic rd_reg(input logic [3:0] r, output logic [15:0] v);
    wr(1'b1, {12'h0, r});
    rd(1'b0, v);
  endtask

  task automatic pulse_ev(input int i);
    @(negedge clk);
    ev = 7'(1 << i);
    @(negedge clk);
    ev = '0;
  endtask

  function automatic logic [15:0] pat(input int r, input int k);
    return 16'h5A3C ^ (16'(r) * 16'h1357) ^ 16'(k * 16'h0F0F);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic [15:0] expw [16];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2 reset state
    rd(1'b0, v);        check("R2 reg0 reset", 64'(v), 64'h0004);
    rd(1'b1, v);        check("R2 selector reset", 64'(v), 64'h0);
    check("R2 irq reset", 64'(irq), 64'h0);
    check("R2 tx_demand reset", 64'(tx_demand), 64'h0);
    for (int r = 1; r < 16; r++) begin
      rd_reg(4'(r), v); check($sformatf("R2 reg%0d reset", r), 64'(v), 64'h0);
    end

    // R1 selector readback and upper bits dropped
    for (int r = 0; r < 16; r++) begin
      wr(1'b1, 16'hFFF0 | 16'(r));
      rd(1'b1, v); check($sformatf("R1 selector %0d", r), 64'(v), 64'(r));
    end

    // R9 R10 R11 writes while stopped; R1 unused numbers
    for (int r = 1; r < 16; r++) begin
      wr(1'b1, 16'(r));
      wr(1'b0, pat(r, 0));
      case (r)
        1, 8, 9, 10, 11, 15: expw[r] = pat(r, 0);
        2:                   expw[r] = pat(r, 0) & 16'h00FF;
        3:                   expw[r] = pat(r, 0) & 16'h0007;
        default:             expw[r] = 16'h0;
      endcase
    end
    for (int r = 1; r < 16; r++) begin
      rd_reg(4'(r), v);
      check($sformatf("R1 R9 R10 R11 reg%0d readback", r), 64'(v), 64'(expw[r]));
    end
    check("R9 init_addr port", 64'(init_addr), 64'({expw[2][7:0], expw[1]}));
    check("R10 bus_cfg port", 64'(bus_cfg), 64'(expw[3][2:0]));
    check("R11 filter port", mcast_filter, {expw[11], expw[10], expw[9], expw[8]});
    check("R11 mode port", 64'(mode_word), 64'(expw[15]));
    wr(1'b1, 16'd15); wr(1'b0, 16'h8000);
    check("R11 promisc on", 64'(promisc), 64'h1);
    wr(1'b0, 16'h7FFF);
    check("R11 promisc off", 64'(promisc), 64'h0);
    expw[15] = 16'h7FFF;

    // R3 init with stop
    wr(1'b1, 16'd0);
    wr(1'b0, 16'h0005);
    rd(1'b0, v); check("R3 init+stop", 64'(v), 64'h0004);

    // R4 start, init, sticky bits
    wr(1'b0, 16'h0002);
    rd(1'b0, v); check("R4 start", 64'(v), 64'h0032);
    check("R4 tx_on rx_on", 64'({tx_on, rx_on, stopped}), 64'b110);
    wr(1'b0, 16'h0001);
    rd(1'b0, v); check("R4 init", 64'(v), 64'h0033);
    wr(1'b0, 16'h0000);
    rd(1'b0, v); check("R4 zero write keeps", 64'(v), 64'h0033);

    // R12 writes while running are ignored
    for (int r = 1; r < 16; r++) begin
      wr(1'b1, 16'(r));
      wr(1'b0, pat(r, 1));
    end
    for (int r = 1; r < 16; r++) begin
      rd_reg(4'(r), v);
      check($sformatf("R12 reg%0d locked", r), 64'(v), 64'(expw[r]));
    end
    check("R12 init_addr port", 64'(init_addr), 64'({expw[2][7:0], expw[1]}));

    // R5 transmit demand pulse
    wr(1'b1, 16'd0);
    wr(1'b0, 16'h0008);
    check("R5 demand high", 64'(tx_demand), 64'h1);
    @(negedge clk);
    check("R5 demand low", 64'(tx_demand), 64'h0);
    rd(1'b0, v); check("R5 bit3 reads 0", 64'(v), 64'h0033);
    wr(1'b0, 16'h000C);
    check("R5 demand blocked by stop", 64'(tx_demand), 64'h0);
    wr(1'b0, 16'h0042);
    rd(1'b0, v); check("R4 restart with ie", 64'(v), 64'h0072);

    // R6 R7 R8 flag sweep
    for (int i = 0; i < 7; i++) begin
      logic [15:0] e;
      e = 16'h0072 | 16'(1 << (8 + i)) | 16'h0080 | ((i >= 3) ? 16'h8000 : 16'h0);
      pulse_ev(i);
      rd(1'b0, v); check($sformatf("R6 R7 flag %0d set", i), 64'(v), 64'(e));
      check($sformatf("R8 irq flag %0d", i), 64'(irq), 64'h1);
      wr(1'b0, 16'h0040);
      rd(1'b0, v); check($sformatf("R6 flag %0d write0 keeps", i), 64'(v), 64'(e));
      wr(1'b0, 16'h0040 | 16'(1 << (8 + i)));
      rd(1'b0, v); check($sformatf("R6 flag %0d cleared", i), 64'(v), 64'h0072);
      check($sformatf("R8 irq low %0d", i), 64'(irq), 64'h0);
    end

    // R6 event during its own clear
    pulse_ev(1);
    @(negedge clk);
    bus_port = 1'b0; bus_wdata = 16'h0240; bus_wr = 1'b1; ev = 7'b0000010;
    @(negedge clk);
    bus_wr = 1'b0; ev = '0;
    rd(1'b0, v); check("R6 set beats clear", 64'(v), 64'h02F2);

    // R8 irq needs enable; R7 two errors
    wr(1'b0, 16'h0002);
    check("R8 irq masked", 64'(irq), 64'h0);
    pulse_ev(4); pulse_ev(6);
    rd(1'b0, v); check("R7 multi flags", 64'(v), 64'hD2B2);
    wr(1'b0, 16'h1042);
    rd(1'b0, v); check("R7 one error left", 64'(v), 64'hC2F2);
    check("R8 irq enabled", 64'(irq), 64'h1);
    wr(1'b0, 16'h4204);
    rd(1'b0, v); check("R3 stop clears ie", 64'(v), 64'h0004);
    check("R8 irq after stop", 64'(irq), 64'h0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule